// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block freezes the running system time at the moment a timing-protocol packet crosses the port. It has two capture slots, one for receive and one for transmit. Each slot holds a 64-bit stamp that software reads as two 32-bit words. A packet-event strobe copies the live system time into a slot only when the packet qualifies. The copy also raises that slot's valid flag, which software polls to learn that a stamp is waiting.

After a capture the slot is locked. It keeps its stamp and ignores every further packet until software reads the high word. That read returns the upper half, drops the valid flag and re-arms the slot. Reading the low word returns the lower half and leaves the lock in place, so the usual order is low word first, then high word. Receive packets qualify through a mode field and a message register. The message register holds a UDP port in bits 31:16 and a message code in bits 15:0. A separate pair of enables admits layer-2 frames. An upstream parser presents the packet fields already decoded. Transmit packets qualify when the transmit enable is set and the strobe carries the stamp mark.

Each slot is a two-state machine with the states SLOT_ARMED and SLOT_LOCKED. The CAPTURE transition goes from SLOT_ARMED to SLOT_LOCKED on a qualified strobe. The RELEASE transition goes from SLOT_LOCKED to SLOT_ARMED on a high-word read. A qualified strobe in SLOT_LOCKED keeps the slot in SLOT_LOCKED and changes nothing. A high-word read in SLOT_ARMED keeps the slot in SLOT_ARMED.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset, rx_valid and tx_valid are 0 and both read-data outputs are 0.
- R2: If a qualified receive strobe arrives while the receive slot is armed, the slot stores the sys_time value present at that clock edge. rx_valid is 1 from the next cycle.
- R3: While a slot is locked, later strobes leave its stored stamp and valid flag unchanged, whether or not they qualify.
- R4: A low-word read puts bits 31:0 of the stored stamp on the read-data output one cycle later. It keeps the slot locked, so valid stays 1 and a later qualified strobe is not captured.
- R5: A high-word read puts bits 63:32 on the read-data output one cycle later. It clears valid in that same cycle, and the next qualified strobe captures again.
- R6: cfg_rx_mode = 2'b01 selects version-1 UDP mode. A strobe qualifies only if the packet is not layer-2, its version field is 1, its UDP port equals cfg_rx_msg[31:16], and its message type equals cfg_rx_msg[15:0].
- R7: cfg_rx_mode = 2'b10 selects version-2 event mode. A strobe qualifies if the version field is 2 and the message type is 0 to 3, whatever code cfg_rx_msg[15:0] holds. Types 4 and above never qualify. A UDP packet must also match the port in cfg_rx_msg[31:16].
- R8: In version-2 event mode, a layer-2 frame qualifies only if its ethertype is 0x88F7 and both cfg_l2_filt_en and cfg_l2_stamp_en are 1.
- R9: If cfg_rx_en is 0, or cfg_rx_mode is 2'b00 or 2'b11, no receive capture takes place.
- R10: A transmit strobe captures only if tx_pkt_mark and cfg_tx_en are both 1. An unmarked strobe, or any strobe while cfg_tx_en is 0, is ignored.
- R11: The two slots are independent. A read of one slot never releases or changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Live system time |
| cfg_rx_en | input | 1 | Receive capture enable |
| cfg_rx_mode | input | 2 | Receive mode: 01 v1 UDP, 10 v2 event, other values off |
| cfg_rx_msg | input | 32 | UDP port in [31:16], message code in [15:0] |
| cfg_l2_filt_en | input | 1 | Layer-2 ethertype filter enable |
| cfg_l2_stamp_en | input | 1 | Layer-2 stamp enable |
| cfg_tx_en | input | 1 | Transmit capture enable |
| rx_pkt_stb | input | 1 | Receive packet event strobe |
| rx_pkt_is_l2 | input | 1 | Receive packet is a layer-2 frame |
| rx_pkt_ethtype | input | 16 | Decoded ethertype |
| rx_pkt_udp_port | input | 16 | Decoded UDP destination port |
| rx_pkt_ver | input | 4 | Decoded protocol version |
| rx_pkt_msg_type | input | 4 | Decoded message type |
| tx_pkt_stb | input | 1 | Transmit packet event strobe |
| tx_pkt_mark | input | 1 | Transmit packet is marked for stamping |
| rx_rd_lo | input | 1 | Read receive low word |
| rx_rd_hi | input | 1 | Read receive high word and release |
| tx_rd_lo | input | 1 | Read transmit low word |
| tx_rd_hi | input | 1 | Read transmit high word and release |
| rx_valid | output | 1 | Receive stamp held |
| rx_rdata | output | 32 | Receive read data |
| tx_valid | output | 1 | Transmit stamp held |
| tx_rdata | output | 32 | Transmit read data |

## Verification
The assertions check the slot behaviour on every cycle. They cover capture of the edge's system time, a frozen stamp while locked, release by a high-word read only, and persistence of the lock across low-word reads. They also check that a disabled receive side, or an unmarked or disabled transmit strobe, never raises valid. The assertions cannot judge whether a particular packet should qualify, so the filter decisions rest on the bench's scenarios. Those scenarios cover version, port, message code, event type range, ethertype and the layer-2 enables. The scenarios also show the word values that software actually reads back and the independence of the two slots.

// File: rtl/ts_latch_pkg.sv
package ts_latch_pkg;

    typedef enum logic [1:0] {
        RXM_OFF      = 2'b00,
        RXM_V1_UDP   = 2'b01,
        RXM_V2_EVENT = 2'b10,
        RXM_RSVD     = 2'b11
    } rx_mode_e;

    typedef enum logic {
        SLOT_ARMED  = 1'b0,
        SLOT_LOCKED = 1'b1
    } slot_state_e;

    localparam int unsigned V2_EVENT_MAX = 3;
    localparam int unsigned NUM_SLOTS    = 2;
    localparam int unsigned SLOT_RX      = 0;
    localparam int unsigned SLOT_TX      = 1;

endpackage

// File: rtl/ts_rx_qualifier.sv
module ts_rx_qualifier
    import ts_latch_pkg::*;
#(
    parameter int unsigned PORT_W  = 16,
    parameter int unsigned MSG_W   = 32,
    parameter int unsigned ETH_W   = 16,
    parameter int unsigned VER_W   = 4,
    parameter int unsigned MTYPE_W = 4,
    parameter logic [ETH_W-1:0] ETH_PTP_TYPE = 16'h88F7
) (
    input  logic               cfg_en,
    input  logic [1:0]         cfg_mode,
    input  logic [MSG_W-1:0]   cfg_msg,
    input  logic               cfg_l2_filt_en,
    input  logic               cfg_l2_stamp_en,
    input  logic               pkt_stb,
    input  logic               pkt_is_l2,
    input  logic [ETH_W-1:0]   pkt_ethtype,
    input  logic [PORT_W-1:0]  pkt_udp_port,
    input  logic [VER_W-1:0]   pkt_ver,
    input  logic [MTYPE_W-1:0] pkt_msg_type,
    output logic               qual
);

    localparam int unsigned CODE_W = MSG_W - PORT_W;

    rx_mode_e mode;
    logic     port_ok;
    logic     code_ok;
    logic     ev_type;
    logic     udp_ok;
    logic     l2_ok;
    logic     match;

    assign mode = rx_mode_e'(cfg_mode);

    always_comb begin
        port_ok = (pkt_udp_port == cfg_msg[MSG_W-1 -: PORT_W]);
        code_ok = (cfg_msg[CODE_W-1:0] == CODE_W'(pkt_msg_type));
        ev_type = (pkt_msg_type <= MTYPE_W'(V2_EVENT_MAX));
        udp_ok  = !pkt_is_l2 && port_ok;
        l2_ok   = pkt_is_l2 && cfg_l2_filt_en && cfg_l2_stamp_en
                  && (pkt_ethtype == ETH_PTP_TYPE);
        match   = 1'b0;
        unique case (mode)
            RXM_V1_UDP:   match = udp_ok && (pkt_ver == VER_W'(1)) && code_ok;
            RXM_V2_EVENT: match = (pkt_ver == VER_W'(2)) && ev_type && (udp_ok || l2_ok);
            RXM_OFF:      match = 1'b0;
            RXM_RSVD:     match = 1'b0;
            default:      match = 1'b0;
        endcase
        qual = pkt_stb && cfg_en && match;
    end

endmodule

// File: rtl/ts_capture_slot.sv
module ts_capture_slot
    import ts_latch_pkg::*;
#(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned WORD_W = TIME_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qual,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [TIME_W-1:0] time_in,
    output logic              valid,
    output logic [WORD_W-1:0] rdata,
    output logic [TIME_W-1:0] stamp
);

    slot_state_e       state_q, state_d;
    logic [TIME_W-1:0] stamp_q;
    logic [WORD_W-1:0] rdata_q;
    logic              take;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_ARMED;
        else        state_q <= state_d;
    end

    // transitions: CAPTURE and RELEASE
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            SLOT_ARMED: begin
                if (qual) begin
                    state_d = SLOT_LOCKED;
                    take    = 1'b1;
                end
            end
            SLOT_LOCKED: begin
                if (rd_hi) state_d = SLOT_ARMED;
            end
            default: state_d = SLOT_ARMED;
        endcase
    end

    // stamp and read-data outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q <= '0;
            rdata_q <= '0;
        end else begin
            if (take) stamp_q <= time_in;
            if (rd_hi)      rdata_q <= stamp_q[TIME_W-1 -: WORD_W];
            else if (rd_lo) rdata_q <= stamp_q[WORD_W-1:0];
        end
    end

    assign valid = (state_q == SLOT_LOCKED);
    assign rdata = rdata_q;
    assign stamp = stamp_q;

endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
    import ts_latch_pkg::*;
#(
    parameter int unsigned TIME_W  = 64,
    parameter int unsigned PORT_W  = 16,
    parameter int unsigned MSG_W   = 32,
    parameter int unsigned ETH_W   = 16,
    parameter int unsigned VER_W   = 4,
    parameter int unsigned MTYPE_W = 4,
    parameter logic [15:0] ETH_PTP_TYPE = 16'h88F7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TIME_W-1:0]    sys_time,
    input  logic                 cfg_rx_en,
    input  logic [1:0]           cfg_rx_mode,
    input  logic [MSG_W-1:0]     cfg_rx_msg,
    input  logic                 cfg_l2_filt_en,
    input  logic                 cfg_l2_stamp_en,
    input  logic                 cfg_tx_en,
    input  logic                 rx_pkt_stb,
    input  logic                 rx_pkt_is_l2,
    input  logic [ETH_W-1:0]     rx_pkt_ethtype,
    input  logic [PORT_W-1:0]    rx_pkt_udp_port,
    input  logic [VER_W-1:0]     rx_pkt_ver,
    input  logic [MTYPE_W-1:0]   rx_pkt_msg_type,
    input  logic                 tx_pkt_stb,
    input  logic                 tx_pkt_mark,
    input  logic                 rx_rd_lo,
    input  logic                 rx_rd_hi,
    input  logic                 tx_rd_lo,
    input  logic                 tx_rd_hi,
    output logic                 rx_valid,
    output logic [TIME_W/2-1:0]  rx_rdata,
    output logic                 tx_valid,
    output logic [TIME_W/2-1:0]  tx_rdata
);

    localparam int unsigned WORD_W = TIME_W / 2;

    logic                 rx_qual;
    logic                 tx_qual;
    logic [TIME_W-1:0]    rx_stamp;
    logic [TIME_W-1:0]    tx_stamp;

    logic [NUM_SLOTS-1:0] slot_qual;
    logic [NUM_SLOTS-1:0] slot_lo;
    logic [NUM_SLOTS-1:0] slot_hi;
    logic [NUM_SLOTS-1:0] slot_valid;
    logic [WORD_W-1:0]    slot_rdata [NUM_SLOTS];
    logic [TIME_W-1:0]    slot_stamp [NUM_SLOTS];

    ts_rx_qualifier #(
        .PORT_W       (PORT_W),
        .MSG_W        (MSG_W),
        .ETH_W        (ETH_W),
        .VER_W        (VER_W),
        .MTYPE_W      (MTYPE_W),
        .ETH_PTP_TYPE (ETH_W'(ETH_PTP_TYPE))
    ) u_rx_qual (
        .cfg_en          (cfg_rx_en),
        .cfg_mode        (cfg_rx_mode),
        .cfg_msg         (cfg_rx_msg),
        .cfg_l2_filt_en  (cfg_l2_filt_en),
        .cfg_l2_stamp_en (cfg_l2_stamp_en),
        .pkt_stb         (rx_pkt_stb),
        .pkt_is_l2       (rx_pkt_is_l2),
        .pkt_ethtype     (rx_pkt_ethtype),
        .pkt_udp_port    (rx_pkt_udp_port),
        .pkt_ver         (rx_pkt_ver),
        .pkt_msg_type    (rx_pkt_msg_type),
        .qual            (rx_qual)
    );

    assign tx_qual = tx_pkt_stb && tx_pkt_mark && cfg_tx_en;

    assign slot_qual[SLOT_RX] = rx_qual;
    assign slot_qual[SLOT_TX] = tx_qual;
    assign slot_lo[SLOT_RX]   = rx_rd_lo;
    assign slot_lo[SLOT_TX]   = tx_rd_lo;
    assign slot_hi[SLOT_RX]   = rx_rd_hi;
    assign slot_hi[SLOT_TX]   = tx_rd_hi;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        ts_capture_slot #(
            .TIME_W (TIME_W),
            .WORD_W (WORD_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .qual    (slot_qual[s]),
            .rd_lo   (slot_lo[s]),
            .rd_hi   (slot_hi[s]),
            .time_in (sys_time),
            .valid   (slot_valid[s]),
            .rdata   (slot_rdata[s]),
            .stamp   (slot_stamp[s])
        );
    end

    assign rx_valid = slot_valid[SLOT_RX];
    assign tx_valid = slot_valid[SLOT_TX];
    assign rx_rdata = slot_rdata[SLOT_RX];
    assign tx_rdata = slot_rdata[SLOT_TX];
    assign rx_stamp = slot_stamp[SLOT_RX];
    assign tx_stamp = slot_stamp[SLOT_TX];

endmodule

// File: rtl/ts_capture_latch_chk.sv
module ts_capture_latch_chk #(
    parameter int unsigned TIME_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] sys_time,
    input logic              cfg_rx_en,
    input logic              cfg_tx_en,
    input logic              tx_pkt_stb,
    input logic              tx_pkt_mark,
    input logic              rx_qual,
    input logic              rx_rd_lo,
    input logic              rx_rd_hi,
    input logic              tx_rd_hi,
    input logic              rx_valid,
    input logic              tx_valid,
    input logic [TIME_W-1:0] rx_stamp,
    input logic [TIME_W-1:0] tx_stamp
);

    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && rx_qual) |=> (rx_valid && rx_stamp == $past(sys_time))); // R2

    AST_RX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_rd_hi) |=> (rx_valid && $stable(rx_stamp))); // R3

    AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_rd_hi) |=> (tx_valid && $stable(tx_stamp))); // R3

    AST_LOW_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_rd_lo && !rx_rd_hi) |=> rx_valid); // R4

    AST_HIGH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_rd_hi) |=> !rx_valid); // R5

    AST_RX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rx_en && !rx_valid) |=> !rx_valid); // R9

    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !(tx_pkt_stb && tx_pkt_mark && cfg_tx_en)) |=> !tx_valid); // R10

    AST_TX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && tx_pkt_stb && tx_pkt_mark && cfg_tx_en)
            |=> (tx_valid && tx_stamp == $past(sys_time))); // R10

endmodule

bind ts_capture_latch ts_capture_latch_chk #(.TIME_W(TIME_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_time    (sys_time),
    .cfg_rx_en   (cfg_rx_en),
    .cfg_tx_en   (cfg_tx_en),
    .tx_pkt_stb  (tx_pkt_stb),
    .tx_pkt_mark (tx_pkt_mark),
    .rx_qual     (rx_qual),
    .rx_rd_lo    (rx_rd_lo),
    .rx_rd_hi    (rx_rd_hi),
    .tx_rd_hi    (tx_rd_hi),
    .rx_valid    (rx_valid),
    .tx_valid    (tx_valid),
    .rx_stamp    (rx_stamp),
    .tx_stamp    (tx_stamp)
);

// File: tb/ts_capture_latch_test.sv
`timescale 1ns/1ps
module ts_capture_latch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_time = '0;
    logic        cfg_rx_en = 1'b0;
    logic [1:0]  cfg_rx_mode = 2'b00;
    logic [31:0] cfg_rx_msg = '0;
    logic        cfg_l2_filt_en = 1'b0;
    logic        cfg_l2_stamp_en = 1'b0;
    logic        cfg_tx_en = 1'b0;
    logic        rx_pkt_stb = 1'b0;
    logic        rx_pkt_is_l2 = 1'b0;
    logic [15:0] rx_pkt_ethtype = '0;
    logic [15:0] rx_pkt_udp_port = '0;
    logic [3:0]  rx_pkt_ver = '0;
    logic [3:0]  rx_pkt_msg_type = '0;
    logic        tx_pkt_stb = 1'b0;
    logic        tx_pkt_mark = 1'b0;
    logic        rx_rd_lo = 1'b0;
    logic        rx_rd_hi = 1'b0;
    logic        tx_rd_lo = 1'b0;
    logic        tx_rd_hi = 1'b0;
    logic        rx_valid;
    logic [31:0] rx_rdata;
    logic        tx_valid;
    logic [31:0] tx_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ts_capture_latch uut (
        .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
        .cfg_rx_en(cfg_rx_en), .cfg_rx_mode(cfg_rx_mode), .cfg_rx_msg(cfg_rx_msg),
        .cfg_l2_filt_en(cfg_l2_filt_en), .cfg_l2_stamp_en(cfg_l2_stamp_en),
        .cfg_tx_en(cfg_tx_en),
        .rx_pkt_stb(rx_pkt_stb), .rx_pkt_is_l2(rx_pkt_is_l2),
        .rx_pkt_ethtype(rx_pkt_ethtype), .rx_pkt_udp_port(rx_pkt_udp_port),
        .rx_pkt_ver(rx_pkt_ver), .rx_pkt_msg_type(rx_pkt_msg_type),
        .tx_pkt_stb(tx_pkt_stb), .tx_pkt_mark(tx_pkt_mark),
        .rx_rd_lo(rx_rd_lo), .rx_rd_hi(rx_rd_hi),
        .tx_rd_lo(tx_rd_lo), .tx_rd_hi(tx_rd_hi),
        .rx_valid(rx_valid), .rx_rdata(rx_rdata),
        .tx_valid(tx_valid), .tx_rdata(tx_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one receive packet event; returns at the following negedge
    task automatic rx_pkt(input logic [3:0] ver, input bit l2, input logic [15:0] eth,
                          input logic [15:0] port, input logic [3:0] mt, input logic [63:0] t);
        rx_pkt_ver = ver; rx_pkt_is_l2 = l2; rx_pkt_ethtype = eth;
        rx_pkt_udp_port = port; rx_pkt_msg_type = mt; sys_time = t;
        rx_pkt_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_pkt_stb = 1'b0;
    endtask

    task automatic tx_pkt(input bit mark, input logic [63:0] t);
        tx_pkt_mark = mark; sys_time = t; tx_pkt_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_pkt_stb = 1'b0; tx_pkt_mark = 1'b0;
    endtask

    task automatic rd(input bit tx, input bit hi, output logic [31:0] d);
        if (tx) begin tx_rd_lo = !hi; tx_rd_hi = hi; end
        else    begin rx_rd_lo = !hi; rx_rd_hi = hi; end
        @(posedge clk);
        @(negedge clk);
        rx_rd_lo = 1'b0; rx_rd_hi = 1'b0; tx_rd_lo = 1'b0; tx_rd_hi = 1'b0;
        d = tx ? tx_rdata : rx_rdata;
    endtask

    task automatic t_reset;
        chk(rx_valid == 1'b0, "R1 rx_valid", 64'(rx_valid), 0);
        chk(tx_valid == 1'b0, "R1 tx_valid", 64'(tx_valid), 0);
        chk(rx_rdata == 32'h0, "R1 rx_rdata", 64'(rx_rdata), 0);
        chk(tx_rdata == 32'h0, "R1 tx_rdata", 64'(tx_rdata), 0);
    endtask

    task automatic t_v1_udp;
        logic [31:0] d;
        cfg_rx_en = 1'b1; cfg_rx_mode = 2'b01; cfg_rx_msg = {16'd319, 16'd0};
        rx_pkt(4'd1, 1'b0, 16'h0, 16'd319, 4'd1, 64'h1);
        chk(!rx_valid, "R6 code mismatch", 64'(rx_valid), 0);
        rx_pkt(4'd1, 1'b0, 16'h0, 16'd320, 4'd0, 64'h2);
        chk(!rx_valid, "R6 port mismatch", 64'(rx_valid), 0);
        rx_pkt(4'd2, 1'b0, 16'h0, 16'd319, 4'd0, 64'h3);
        chk(!rx_valid, "R6 version mismatch", 64'(rx_valid), 0);
        rx_pkt(4'd1, 1'b1, 16'h88F7, 16'd319, 4'd0, 64'h4);
        chk(!rx_valid, "R6 layer-2 frame", 64'(rx_valid), 0);
        rx_pkt(4'd1, 1'b0, 16'h0, 16'd319, 4'd0, 64'h1122_3344_5566_7788);
        chk(rx_valid, "R2 capture valid", 64'(rx_valid), 1);
        rd(1'b0, 1'b0, d);
        chk(d == 32'h5566_7788, "R4 low word", 64'(d), 64'h5566_7788);
        chk(rx_valid, "R4 lock kept after low read", 64'(rx_valid), 1);
        rx_pkt(4'd1, 1'b0, 16'h0, 16'd319, 4'd0, 64'hAAAA_BBBB_CCCC_DDDD);
        rd(1'b0, 1'b0, d);
        chk(d == 32'h5566_7788, "R3 stamp frozen while locked", 64'(d), 64'h5566_7788);
        rd(1'b0, 1'b1, d);
        chk(d == 32'h1122_3344, "R5 high word", 64'(d), 64'h1122_3344);
        chk(!rx_valid, "R5 valid cleared", 64'(rx_valid), 0);
        rx_pkt(4'd1, 1'b0, 16'h0, 16'd319, 4'd0, 64'h0BAD_F00D_0000_0001);
        chk(rx_valid, "R5 re-armed capture", 64'(rx_valid), 1);
        rd(1'b0, 1'b1, d);
        chk(d == 32'h0BAD_F00D, "R5 new high word", 64'(d), 64'h0BAD_F00D);
    endtask

    task automatic t_v2_event;
        logic [31:0] d;
        cfg_rx_mode = 2'b10; cfg_rx_msg = {16'd319, 16'd1};
        rx_pkt(4'd2, 1'b0, 16'h0, 16'd319, 4'd5, 64'h10);
        chk(!rx_valid, "R7 non-event type", 64'(rx_valid), 0);
        rx_pkt(4'd2, 1'b0, 16'h0, 16'd400, 4'd0, 64'h11);
        chk(!rx_valid, "R7 port mismatch", 64'(rx_valid), 0);
        rx_pkt(4'd2, 1'b0, 16'h0, 16'd319, 4'd2, 64'h0000_0007_0000_0009);
        chk(rx_valid, "R7 path-delay type despite code", 64'(rx_valid), 1);
        rd(1'b0, 1'b1, d);
        chk(d == 32'h7, "R7 stamp high", 64'(d), 64'h7);
        rx_pkt(4'd2, 1'b0, 16'h0, 16'd319, 4'd3, 64'h12);
        chk(rx_valid, "R7 type 3 boundary", 64'(rx_valid), 1);
        rd(1'b0, 1'b1, d);
    endtask

    task automatic t_layer2;
        logic [31:0] d;
        cfg_rx_mode = 2'b10;
        cfg_l2_filt_en = 1'b0; cfg_l2_stamp_en = 1'b0;
        rx_pkt(4'd2, 1'b1, 16'h88F7, 16'd0, 4'd0, 64'h20);
        chk(!rx_valid, "R8 filters off", 64'(rx_valid), 0);
        cfg_l2_filt_en = 1'b1;
        rx_pkt(4'd2, 1'b1, 16'h88F7, 16'd0, 4'd0, 64'h21);
        chk(!rx_valid, "R8 stamp enable off", 64'(rx_valid), 0);
        cfg_l2_stamp_en = 1'b1;
        rx_pkt(4'd2, 1'b1, 16'h88F6, 16'd0, 4'd0, 64'h22);
        chk(!rx_valid, "R8 wrong ethertype", 64'(rx_valid), 0);
        rx_pkt(4'd2, 1'b1, 16'h88F7, 16'd0, 4'd1, 64'hFEED_0000_0000_0023);
        chk(rx_valid, "R8 layer-2 capture", 64'(rx_valid), 1);
        rd(1'b0, 1'b0, d);
        chk(d == 32'h23, "R8 stamp low", 64'(d), 64'h23);
        rd(1'b0, 1'b1, d);
        chk(d == 32'hFEED_0000, "R8 stamp high", 64'(d), 64'hFEED_0000);
    endtask

    task automatic t_disable;
        cfg_rx_mode = 2'b01; cfg_rx_msg = {16'd319, 16'd0}; cfg_rx_en = 1'b0;
        rx_pkt(4'd1, 1'b0, 16'h0, 16'd319, 4'd0, 64'h30);
        chk(!rx_valid, "R9 enable off", 64'(rx_valid), 0);
        cfg_rx_en = 1'b1; cfg_rx_mode = 2'b00;
        rx_pkt(4'd1, 1'b0, 16'h0, 16'd319, 4'd0, 64'h31);
        chk(!rx_valid, "R9 mode 00", 64'(rx_valid), 0);
        cfg_rx_mode = 2'b11;
        rx_pkt(4'd2, 1'b0, 16'h0, 16'd319, 4'd0, 64'h32);
        chk(!rx_valid, "R9 mode 11", 64'(rx_valid), 0);
    endtask

    task automatic t_transmit;
        logic [31:0] d;
        cfg_tx_en = 1'b1;
        tx_pkt(1'b0, 64'h40);
        chk(!tx_valid, "R10 unmarked ignored", 64'(tx_valid), 0);
        tx_pkt(1'b1, 64'hCAFE_0001_BEEF_0002);
        chk(tx_valid, "R10 marked capture", 64'(tx_valid), 1);
        cfg_rx_mode = 2'b01; cfg_rx_msg = {16'd319, 16'd0};
        rx_pkt(4'd1, 1'b0, 16'h0, 16'd319, 4'd0, 64'h5);
        rd(1'b0, 1'b1, d);
        chk(tx_valid, "R11 rx read keeps tx lock", 64'(tx_valid), 1);
        rx_pkt(4'd1, 1'b0, 16'h0, 16'd319, 4'd0, 64'h6);
        tx_pkt(1'b1, 64'h41);
        rd(1'b1, 1'b0, d);
        chk(d == 32'hBEEF_0002, "R3 tx frozen low", 64'(d), 64'hBEEF_0002);
        rd(1'b1, 1'b1, d);
        chk(d == 32'hCAFE_0001, "R5 tx high", 64'(d), 64'hCAFE_0001);
        chk(!tx_valid, "R5 tx released", 64'(tx_valid), 0);
        chk(rx_valid, "R11 tx read keeps rx lock", 64'(rx_valid), 1);
        cfg_tx_en = 1'b0;
        tx_pkt(1'b1, 64'h42);
        chk(!tx_valid, "R10 tx disabled", 64'(tx_valid), 0);
        rd(1'b0, 1'b1, d);
        chk(d == 32'h0, "R11 rx stamp high", 64'(d), 64'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_v1_udp();
        t_v2_event();
        t_layer2();
        t_disable();
        t_transmit();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule